// File: doc/BRIEF.md
# Serial Debug Access Port with Trap Control Register

This block gives an external debug host a bit-serial path into a processor while everything inside runs on the system clock. The host drives a serial clock and a serial data line. Neither is related to the system clock, so both pass through flip-flop synchronizers. Every rising edge of the synchronized serial clock shifts one bit into a 35-bit frame register. When a frame is complete, its top bits decide where the contents go. Either a 32-bit word plus one control flag is presented to the processor with a one-cycle valid strobe, or the low nine bits are written into a trap control register. That register drives six trap enables, two breakpoint requests and one sync request.

The processor can also write a 32-bit word into the frame register. The host then reads it back by clocking the serial line again: each serial clock edge presents the next bit on the serial output, most significant bit first. Bits shifted in during such a readback form the next incoming frame.

Top module: `serial_dbg_port`

## Requirements
- R1: After synchronous reset, every output is 0: serial output, valid strobe, processor word, control flag, trap enables, breakpoints and sync.
- R2: Each rising edge of the serial clock, after a two-flop synchronizer, produces exactly one shift. Serial data is sampled through an equal-depth synchronizer.
- R3: Shifting is MSB first. The serial output always shows frame bit 34. New input enters at bit 0. The output changes only on a shift or a processor load.
- R4: A frame is 35 shifts. When bit 34 (start) is 1 and bit 33 (mode) is 0, a one-cycle valid strobe is raised. The processor word shows bits 31:0 and the control flag shows bit 32.
- R5: When start is 1 and mode is 1, bits 8:0 load the trap control register: bits 5:0 drive the trap enables, bits 7:6 the breakpoints and bit 8 the sync output. No valid strobe is raised and the processor word is unchanged.
- R6: A completed frame whose start bit is 0 is discarded. No strobe is raised, no output changes, and the next 35 shifts form a new frame.
- R7: A processor load places the 32-bit word, zero-extended, in the frame register and restarts the bit count. It takes priority over a shift in the same cycle. The next serial output bit is therefore 0.
- R8: The trap outputs change only after a trap frame. The processor word and control flag change only together with the valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial clock from the host, asynchronous |
| ser_din_i | input | 1 | Serial data from the host, asynchronous |
| ser_dout_o | output | 1 | Serial data to the host (frame bit 34) |
| cpu_load_i | input | 1 | Processor load strobe for the frame register |
| cpu_wdata_i | input | 32 | Word loaded by the processor |
| cpu_valid_o | output | 1 | One-cycle strobe for a new processor frame |
| cpu_data_o | output | 32 | Payload of the last processor frame |
| cpu_ctrl_o | output | 1 | Control flag of the last processor frame |
| trap_en_o | output | 6 | Trap enable outputs |
| brk_o | output | 2 | Breakpoint request outputs |
| vsync_o | output | 1 | Sync request output |

## Verification
The assertions assume the serial clock runs at no more than one third of the system clock. They also assume serial data is held for more than one system cycle around each rising serial edge, so that every synchronized edge stands alone and pairs with settled data. The stimulus holds each serial level for four system cycles and changes data two cycles before a rising edge. It issues processor loads only while the serial clock is low and idle, so no load collides with a pending edge.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
    localparam int FRAME_W   = 35;
    localparam int PAYLOAD_W = 32;
    localparam int START_POS = 34;
    localparam int MODE_POS  = 33;
    localparam int CTRL_POS  = 32;
    localparam int N_TRAP    = 6;
    localparam int N_BRK     = 2;
    localparam int TRAP_W    = N_TRAP + N_BRK + 1;
    localparam int CNT_W     = $clog2(FRAME_W);

    typedef struct packed {
        logic [FRAME_W-1:0]   sr;
        logic [CNT_W-1:0]     cnt;
        logic                 valid;
        logic                 trap_ld;
        logic [PAYLOAD_W-1:0] data;
        logic                 ctrl;
        logic [TRAP_W-1:0]    trap_word;
    } shift_state_t;

    typedef struct packed {
        logic [N_TRAP-1:0] trap_en;
        logic [N_BRK-1:0]  brk;
        logic              vsync;
    } trap_state_t;
endpackage

// File: rtl/sdp_sync.sv
module sdp_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb chain_d[s] = async_i;
            end else begin : g_next
                always_comb chain_d[s] = chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdp_edge.sv
module sdp_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb prev_d = level_i;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/sdp_shifter.sv
module sdp_shifter
    import sdp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_i,
    input  logic                 din_i,
    input  logic                 load_i,
    input  logic [PAYLOAD_W-1:0] load_word_i,
    output logic                 dout_o,
    output logic                 valid_o,
    output logic [PAYLOAD_W-1:0] data_o,
    output logic                 ctrl_o,
    output logic                 trap_ld_o,
    output logic [TRAP_W-1:0]    trap_word_o
);
    shift_state_t st_d, st_q;
    logic [FRAME_W-1:0] shifted;

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.trap_ld = 1'b0;
        shifted      = {st_q.sr[FRAME_W-2:0], din_i};
        if (load_i) begin
            st_d.sr  = FRAME_W'(load_word_i);
            st_d.cnt = '0;
        end else if (shift_i) begin
            st_d.sr = shifted;
            if (st_q.cnt == CNT_W'(FRAME_W - 1)) begin
                st_d.cnt = '0;
                if (shifted[START_POS]) begin
                    if (shifted[MODE_POS]) begin
                        st_d.trap_ld   = 1'b1;
                        st_d.trap_word = shifted[TRAP_W-1:0];
                    end else begin
                        st_d.valid = 1'b1;
                        st_d.data  = shifted[PAYLOAD_W-1:0];
                        st_d.ctrl  = shifted[CTRL_POS];
                    end
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout_o      = st_q.sr[FRAME_W-1];
    assign valid_o     = st_q.valid;
    assign data_o      = st_q.data;
    assign ctrl_o      = st_q.ctrl;
    assign trap_ld_o   = st_q.trap_ld;
    assign trap_word_o = st_q.trap_word;
endmodule

// File: rtl/sdp_trapreg.sv
module sdp_trapreg
    import sdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [TRAP_W-1:0] word_i,
    output logic [N_TRAP-1:0] trap_en_o,
    output logic [N_BRK-1:0]  brk_o,
    output logic              vsync_o
);
    localparam int BRK_LO  = N_TRAP;
    localparam int SYNC_AT = N_TRAP + N_BRK;

    trap_state_t tr_d, tr_q;

    always_comb begin
        tr_d = tr_q;
        if (load_i) begin
            tr_d.trap_en = word_i[N_TRAP-1:0];
            tr_d.brk     = word_i[BRK_LO +: N_BRK];
            tr_d.vsync   = word_i[SYNC_AT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tr_q <= '0;
        else     tr_q <= tr_d;
    end

    assign trap_en_o = tr_q.trap_en;
    assign brk_o     = tr_q.brk;
    assign vsync_o   = tr_q.vsync;
endmodule

// File: rtl/serial_dbg_port.sv
module serial_dbg_port
    import sdp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_clk_i,
    input  logic                 ser_din_i,
    output logic                 ser_dout_o,
    input  logic                 cpu_load_i,
    input  logic [PAYLOAD_W-1:0] cpu_wdata_i,
    output logic                 cpu_valid_o,
    output logic [PAYLOAD_W-1:0] cpu_data_o,
    output logic                 cpu_ctrl_o,
    output logic [N_TRAP-1:0]    trap_en_o,
    output logic [N_BRK-1:0]     brk_o,
    output logic                 vsync_o
);
    logic [1:0]        synced;
    logic              shift_en;
    logic              trap_ld;
    logic [TRAP_W-1:0] trap_word;

    sdp_sync #(.STAGES(SYNC_STAGES), .W(2)) sync_i (
        .clk(clk), .rst(rst),
        .async_i({ser_clk_i, ser_din_i}),
        .sync_o(synced)
    );

    sdp_edge edge_i (
        .clk(clk), .rst(rst),
        .level_i(synced[1]),
        .rise_o(shift_en)
    );

    sdp_shifter shift_i (
        .clk(clk), .rst(rst),
        .shift_i(shift_en),
        .din_i(synced[0]),
        .load_i(cpu_load_i),
        .load_word_i(cpu_wdata_i),
        .dout_o(ser_dout_o),
        .valid_o(cpu_valid_o),
        .data_o(cpu_data_o),
        .ctrl_o(cpu_ctrl_o),
        .trap_ld_o(trap_ld),
        .trap_word_o(trap_word)
    );

    sdp_trapreg trap_i (
        .clk(clk), .rst(rst),
        .load_i(trap_ld),
        .word_i(trap_word),
        .trap_en_o(trap_en_o),
        .brk_o(brk_o),
        .vsync_o(vsync_o)
    );
endmodule

// File: rtl/sdp_checker.sv
module sdp_checker (
    input logic        clk,
    input logic        rst,
    input logic        shift_en,
    input logic        cpu_load,
    input logic        dout,
    input logic        valid,
    input logic        trap_ld,
    input logic [31:0] data,
    input logic        ctrl,
    input logic [5:0]  trap_en,
    input logic [1:0]  brk,
    input logic        vsync
);
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    a_r5_no_dual_dest: assert property (@(posedge clk) disable iff (rst)
        !(valid && trap_ld));

    a_r8_trap_hold: assert property (@(posedge clk) disable iff (rst)
        !trap_ld |=> $stable({trap_en, brk, vsync}));

    a_r8_word_hold: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable({data, ctrl}));

    a_r3_dout_hold: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !cpu_load) |=> $stable(dout));

    a_r7_load_zero_msb: assert property (@(posedge clk) disable iff (rst)
        cpu_load |=> !dout);
endmodule

bind serial_dbg_port sdp_checker chk_i (
    .clk(clk), .rst(rst), .shift_en(shift_en), .cpu_load(cpu_load_i),
    .dout(ser_dout_o), .valid(cpu_valid_o), .trap_ld(trap_ld),
    .data(cpu_data_o), .ctrl(cpu_ctrl_o), .trap_en(trap_en_o),
    .brk(brk_o), .vsync(vsync_o)
);

// File: tb/serial_dbg_port_tb.sv
module serial_dbg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_dout;
    logic        cpu_load = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_valid;
    logic [31:0] cpu_data;
    logic        cpu_ctrl;
    logic [5:0]  trap_en;
    logic [1:0]  brk;
    logic        vsync;

    int checks = 0;
    int errors = 0;
    int vcycles = 0;
    bit done = 0;

    logic [31:0] exp_data = '0;
    logic        exp_ctrl = 1'b0;
    logic [8:0]  exp_trap = '0;

    always #5 clk = ~clk;

    serial_dbg_port dut_i (
        .clk(clk), .rst(rst),
        .ser_clk_i(ser_clk), .ser_din_i(ser_din), .ser_dout_o(ser_dout),
        .cpu_load_i(cpu_load), .cpu_wdata_i(cpu_wdata),
        .cpu_valid_o(cpu_valid), .cpu_data_o(cpu_data), .cpu_ctrl_o(cpu_ctrl),
        .trap_en_o(trap_en), .brk_o(brk), .vsync_o(vsync)
    );

    always @(negedge clk) if (cpu_valid) vcycles++;

    function automatic logic [8:0] trap_view();
        return {vsync, brk, trap_en};
    endfunction

    function automatic logic [34:0] make_frame(logic mode, logic ctl, logic [31:0] pay);
        return {1'b1, mode, ctl, pay};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic serial_bit(logic b, output logic seen);
        @(negedge clk) ser_din = b;
        @(negedge clk);
        @(negedge clk) seen = ser_dout;
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_frame(logic [34:0] f, output logic [34:0] seen_bits);
        for (int i = 34; i >= 0; i--) begin
            logic s;
            serial_bit(f[i], s);
            seen_bits[i] = s;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic frame_and_check(logic [34:0] f, string tag);
        int v0;
        logic [34:0] seen;
        v0 = vcycles;
        send_frame(f, seen);
        if (f[34] && !f[33]) begin
            exp_data = f[31:0];
            exp_ctrl = f[32];
        end else if (f[34] && f[33]) begin
            exp_trap = f[8:0];
        end
        check({tag, " strobe cycles"}, 64'(vcycles - v0), (f[34] && !f[33]) ? 64'd1 : 64'd0);
        check({tag, " cpu word"}, {cpu_ctrl, cpu_data}, {exp_ctrl, exp_data});
        check({tag, " trap outputs"}, trap_view(), exp_trap);
    endtask

    task automatic load_and_read(logic [31:0] w);
        logic [34:0] seen;
        @(negedge clk) begin cpu_load = 1'b1; cpu_wdata = w; end
        @(negedge clk) cpu_load = 1'b0;
        send_frame('0, seen);
        check("R7/R3 readback MSB first", seen, {3'b000, w});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset outputs",
              {ser_dout, cpu_valid, cpu_ctrl, cpu_data, trap_view()}, '0);

        void'($urandom(32'h5D1A_0C37));
        // R4 directed processor frame, all ones payload
        frame_and_check(make_frame(1'b0, 1'b1, 32'hFFFF_FFFF), "R4 dir");
        // R5 directed trap frame: trap 6'b101011, brk 2'b10, sync 1
        frame_and_check(make_frame(1'b1, 1'b0, 32'h0000_01AB), "R5 dir");
        // R6 start bit 0 discarded, then R2 rearm with a good frame
        frame_and_check({1'b0, 1'b0, 1'b1, 32'h1234_5678}, "R6 no start");
        frame_and_check({1'b0, 1'b1, 1'b0, 32'h0000_0155}, "R6 no start trap");
        frame_and_check(make_frame(1'b0, 1'b0, 32'h0000_0001), "R2 rearm");
        // R7 readback of processor-loaded words
        load_and_read(32'h8000_0001);
        load_and_read(32'hA5C3_3C5A);
        // R8 random mix
        for (int n = 0; n < 16; n++) begin
            logic [34:0] f;
            f = make_frame(1'($urandom), 1'($urandom), $urandom);
            frame_and_check(f, f[33] ? "R5/R8 rand trap" : "R4/R8 rand cpu");
        end
        load_and_read($urandom);
        frame_and_check(make_frame(1'b1, 1'b1, 32'hFFFF_FE00), "R5 clear trap");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule